// File: doc/BRIEF.md
# Countdown Interrupt Timer with Control Word

This block is a single down-counter that raises an interrupt request when its count runs out. Software sets up a 32-bit control word and then writes a start value to a 32-bit initial-count register. That write loads the running count and starts the countdown. The running count drops by one on every clock, and software can read it back at any time.

When the count expires, the mask field of the control word decides whether a request goes out. An unmasked expiry produces a one-cycle pulse. The pulse carries the 8-bit vector, the 3-bit delivery mode and the trigger-mode bit from the control word. The periodic field decides what happens next:
- In periodic mode the counter reloads from the initial-count register and keeps running.
- In one-shot mode it stops at zero.

How the request is carried and arbitrated after it leaves the block is outside this design. Counting always runs at the full clock rate.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000, which means masked with every other field zero. The initial count and the current count both read zero, and the request outputs are low.
- R2: The control word keeps its fields at these positions: vector in bits 7:0, delivery mode in 10:8, polarity in 13, trigger mode in 15, mask in 16 and periodic in 17. Bits 12 (delivery status) and 14 (remote request) read zero, and so do all other bits. Writing 0xFFFF_FFFF therefore reads back as 0x0003_A7FF.
- R3: Register addresses are 0 for the control word, 1 for the initial count and 2 for the current count. Writing N to address 1 makes the current count read N on the next cycle. After that it reads one less on each following cycle.
- R4: When the count set by a write of N runs out with mask clear, `irq_pulse` is high for the cycle that is N cycles after the write edge. At the same time `irq_vector`, `irq_mode` and `irq_level` equal control bits 7:0, 10:8 and 15.
- R5: With mask set (bit 16 = 1), expiry raises no request.
- R6: With periodic set (bit 17 = 1), the count reads N again in the expiry cycle, and an unmasked timer pulses again every N cycles.
- R7: With periodic clear, the count reads zero from the expiry cycle onward and no further request occurs.
- R8: A masked periodic timer still reloads from the initial count on expiry.
- R9: Writing zero to the initial count stops the timer. The count reads zero and no request follows.
- R10: A write to the initial count on the same edge as an expiry takes priority. That expiry issues no request, and counting restarts from the written value.
- R11: While `irq_pulse` is low, `irq_vector`, `irq_mode` and `irq_level` are all zero.
- R12: Writes to addresses 2 and 3 change nothing, and reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 initial count, 2 current count) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried by the request |
| irq_mode | output | 3 | Delivery mode carried by the request |
| irq_level | output | 1 | Trigger-mode bit carried by the request |

## Verification
An off-by-one in expiry detection moves the request pulse by one cycle, relative to the write edge, on the very first countdown. The bench checks the pulse against the exact cycle, so it catches this at once. A reload that picks the wrong source shows up in the count readback in the expiry cycle itself. A mask or periodic field decoded from the wrong bit either produces a pulse where none is expected or fails to produce one, within N cycles of the start write. A stale or ungated request field shows up on the vector outputs in any cycle without a pulse.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;
  localparam int WORD_W    = 32;
  localparam int VEC_W     = 8;
  localparam int MODE_W    = 3;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int POL_BIT   = 13;
  localparam int LEVEL_BIT = 15;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_INIT = 2'd1,
    ADR_CUR  = 2'd2,
    ADR_NONE = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic              periodic;
    logic              masked;
    logic              level;
    logic              pol;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RESET = '{periodic: 1'b0, masked: 1'b1, level: 1'b0,
                                       pol: 1'b0, mode: '0, vec: '0};

  function automatic tmr_ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
    tmr_ctrl_t c;
    c.vec      = w[VEC_LSB +: VEC_W];
    c.mode     = w[MODE_LSB +: MODE_W];
    c.pol      = w[POL_BIT];
    c.level    = w[LEVEL_BIT];
    c.masked   = w[MASK_BIT];
    c.periodic = w[PER_BIT];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_pack(input tmr_ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VEC_LSB +: VEC_W]   = c.vec;
    w[MODE_LSB +: MODE_W] = c.mode;
    w[POL_BIT]            = c.pol;
    w[LEVEL_BIT]          = c.level;
    w[MASK_BIT]           = c.masked;
    w[PER_BIT]            = c.periodic;
    return w;
  endfunction
endpackage

// File: rtl/irqtmr_ctrl_reg.sv
module irqtmr_ctrl_reg
  import irqtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output tmr_ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= ctrl_unpack(wdata);
  end

  // R1: out of reset the timer stays masked until software writes the control word
  a_r1_reset_masked: assert property (@(posedge clk)
    $rose(rst_n) |-> ctrl_q.masked);
endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_q,
  output logic [CNT_W-1:0] init_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] count_next(
      input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] reload, input logic per);
    if (c == ONE)      return per ? reload : '0;
    else if (c != '0)  return c - ONE;
    else               return '0;
  endfunction

  assign expire = (cur_q == ONE) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      init_q <= '0;
    end else if (load) begin
      cur_q  <= load_val;
      init_q <= load_val;
    end else begin
      cur_q  <= count_next(cur_q, init_q, periodic);
    end
  end

  // R3: a running count above one drops by exactly one
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q > ONE && !load) |=> cur_q == $past(cur_q) - ONE);
  // R6: a periodic expiry reloads the programmed start value
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> cur_q == $past(init_q));
  // R7: a one-shot expiry parks the count at zero
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> cur_q == '0);
endmodule

// File: rtl/irqtmr_emit.sv
module irqtmr_emit
  import irqtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              masked,
  input  logic [VEC_W-1:0]  vec,
  input  logic [MODE_W-1:0] mode,
  input  logic              level,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [MODE_W-1:0] irq_mode,
  output logic              irq_level
);
  logic fire;
  assign fire = expire && !masked;

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_pulse  <= 1'b1;
      irq_vector <= vec;
      irq_mode   <= mode;
      irq_level  <= level;
    end
  end

  // R5: a request always traces back to an unmasked expiry one cycle earlier
  a_r5_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire) && !$past(masked));
  // R11: request fields are quiet whenever no request is shown
  a_r11_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> (irq_vector == '0 && irq_mode == '0 && !irq_level));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import irqtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector,
  output logic [2:0]        irq_mode,
  output logic              irq_level
);
  tmr_ctrl_t        ctrl;
  logic             wr_ctrl, wr_init, expire;
  logic [CNT_W-1:0] cur, init;

  assign wr_ctrl = reg_we && (tmr_addr_e'(reg_addr) == ADR_CTRL);
  assign wr_init = reg_we && (tmr_addr_e'(reg_addr) == ADR_INIT);

  irqtmr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata), .ctrl_q(ctrl)
  );

  irqtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_init), .load_val(reg_wdata[CNT_W-1:0]),
    .periodic(ctrl.periodic), .cur_q(cur), .init_q(init), .expire(expire)
  );

  irqtmr_emit u_emit (
    .clk(clk), .rst_n(rst_n), .expire(expire), .masked(ctrl.masked),
    .vec(ctrl.vec), .mode(ctrl.mode), .level(ctrl.level),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector), .irq_mode(irq_mode),
    .irq_level(irq_level)
  );

  always_comb begin
    case (tmr_addr_e'(reg_addr))
      ADR_CTRL: reg_rdata = ctrl_pack(ctrl);
      ADR_INIT: reg_rdata = WORD_W'(init);
      ADR_CUR:  reg_rdata = WORD_W'(cur);
      default:  reg_rdata = '0;
    endcase
  end

  // R10: a start write on an expiry edge suppresses that expiry's request
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> !irq_pulse);
  // R9: a stopped counter never produces a request
  a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !wr_init) |=> !irq_pulse);
endmodule

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;
  logic        irq_level;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector), .irq_mode(irq_mode), .irq_level(irq_level)
  );

  typedef struct packed { logic [31:0] ctrl; logic [31:0] init; } case_t;
  localparam int NCASE = 6;
  localparam case_t TBL [NCASE] = '{
    '{ctrl: 32'h0000_0041, init: 32'd5},  // one-shot, unmasked
    '{ctrl: 32'h0000_84FE, init: 32'd3},  // one-shot, mode 4, level trigger
    '{ctrl: 32'h0001_0022, init: 32'd4},  // masked one-shot
    '{ctrl: 32'h0002_0230, init: 32'd6},  // periodic, unmasked
    '{ctrl: 32'h0000_8701, init: 32'd1},  // shortest count
    '{ctrl: 32'h0003_0055, init: 32'd2}   // masked periodic
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h0001_0000);
    rd(1, v); chk("R1 init", v, 0);
    rd(2, v); chk("R1 cur", v, 0);
    chk("R1 irq", {31'd0, irq_pulse}, 0);

    // table-driven expiry scenarios: R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NCASE; i++) begin
      logic fire_exp, per;
      int n;
      fire_exp = !TBL[i].ctrl[16];
      per = TBL[i].ctrl[17];
      n = int'(TBL[i].init);
      wr(0, TBL[i].ctrl);
      wr(1, TBL[i].init);
      rd(2, v); chk("R3 load", v, TBL[i].init);
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        chk(fire_exp ? "R4 pulse" : "R5 masked", {31'd0, irq_pulse},
            {31'd0, fire_exp && (k == n)});
        if (k == n && fire_exp) begin
          chk("R4 fields", {20'd0, irq_level, irq_mode, irq_vector},
              {20'd0, TBL[i].ctrl[15], TBL[i].ctrl[10:8], TBL[i].ctrl[7:0]});
        end else begin
          chk("R11 quiet", {20'd0, irq_level, irq_mode, irq_vector}, 0);
        end
        rd(2, v);
        if (k < n)       chk("R3 count", v, 32'(n - k));
        else if (k == n) chk(per ? (fire_exp ? "R6 reload" : "R8 masked reload") : "R7 stop",
                             v, per ? 32'(n) : 0);
      end
      wr(1, 0);
    end

    // R2 field layout and read-only bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 layout", v, 32'h0003_A7FF);
    wr(0, 32'h0001_0000);

    // R12 writes to addresses 2 and 3 ignored
    wr(2, 32'd55); rd(2, v); chk("R12 cur write", v, 0);
    wr(3, 32'h0002_0000); rd(0, v); chk("R12 addr3 write", v, 32'h0001_0000);
    rd(3, v); chk("R12 addr3 read", v, 0);

    // R6 repeated periods
    wr(0, 32'h0002_0077);
    wr(1, 32'd4);
    pulses = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      pulses += int'(irq_pulse);
      chk("R6 period", {31'd0, irq_pulse}, {31'd0, (k % 4) == 0});
    end
    chk("R6 count", 32'(pulses), 3);
    wr(1, 0);

    // R7 one-shot does not restart
    wr(0, 32'h0000_0011);
    wr(1, 32'd3);
    pulses = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      pulses += int'(irq_pulse);
    end
    chk("R7 single pulse", 32'(pulses), 1);
    rd(2, v); chk("R7 parked", v, 0);

    // R9 writing zero stops
    wr(1, 32'd10);
    repeat (3) @(negedge clk);
    wr(1, 0);
    pulses = 0;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      pulses += int'(irq_pulse);
    end
    chk("R9 no pulse", 32'(pulses), 0);
    rd(2, v); chk("R9 stopped", v, 0);

    // R10 start write on the expiry edge
    wr(0, 32'h0000_0055);
    wr(1, 32'd3);
    repeat (2) @(negedge clk);
    wr(1, 32'd7);
    chk("R10 suppressed", {31'd0, irq_pulse}, 0);
    rd(2, v); chk("R10 restart", v, 32'd7);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 7) chk("R10 late pulse", {31'd0, irq_pulse}, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule